// File: doc/BRIEF.md
# Critical-Word-First Line Fill Reorderer

This block sits on the read data path of a cache line fill. The requester asks for a 32-byte line with an address that may point at any word inside it. The block forwards the request downstream with the address forced down to the line boundary, so the line comes back in ascending word order starting at offset 0. It then buffers the returned 8-byte bus words and hands them to the requester in wrapping order, beginning with the word the original address pointed at.

Downstream data may arrive as split bursts, with idle cycles between pieces. Each piece must carry whole 8-byte words. A piece reporting fewer than eight valid bytes aborts the fill and raises a one-cycle error flag. Output begins as soon as the critical word is buffered. Each later beat leaves only once its own word is held. The fourth beat carries a last marker, after which the block is free to take the next request.

Top module: `cwf_reorder`

## Requirements
- R1: While no fill is in progress, `req_valid` is passed to `dn_valid` in the same cycle, and `dn_addr` equals `req_addr` with bits [4:0] forced to zero.
- R2: A request presented while a fill is in progress is not forwarded (`dn_valid` stays 0) and does not change the critical word of the fill in progress.
- R3: Returned words are taken in ascending order (word 0 first), one per `ret_valid` cycle with `ret_bytes` = 8. With c = `req_addr[4:3]` of the accepted request, output beat k (k = 0..3) carries returned word (c + k) mod 4.
- R4: Output beat k appears in the second cycle after the cycle in which its word was returned, or in the cycle after beat k-1, whichever is later. Idle gaps between return pieces are tolerated. No beat is issued before its word has been returned.
- R5: `out_last` is 1 on the fourth output beat only. In the cycle after that beat is issued, the block accepts a new request.
- R6: A return piece with `ret_valid` = 1 and `ret_bytes` other than 8 during a fill raises `out_err` for exactly the following cycle. That error takes precedence over a beat due in the same cycle. The fill is abandoned with no further beats, and the block is ready for a new request.
- R7: `ret_valid` pulses while no fill is in progress are ignored and produce neither beats nor errors.
- R8: After reset, `out_valid`, `out_last` and `out_err` are 0 and no fill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Line fill request from the requester |
| req_addr | input | ADDR_W | Requested address, critical word in bits [4:3] |
| dn_valid | output | 1 | Forwarded request to downstream |
| dn_addr | output | ADDR_W | Line-aligned downstream address |
| ret_valid | input | 1 | Return piece present |
| ret_data | input | DATA_W | Return data word |
| ret_bytes | input | BYTES_W | Valid byte count of the piece |
| out_valid | output | 1 | Reordered beat present |
| out_data | output | DATA_W | Reordered beat data |
| out_last | output | 1 | Fourth beat of the line |
| out_err | output | 1 | Short-piece error, fill abandoned |

## Verification
The bench builds the block with its default parameters: 64-bit bus words and 32-byte lines, so a fill is four beats. At this size every critical word index can be crossed with a set of return split patterns and with every word-offset value inside the critical word. A short piece can be placed at each of the four return positions. Each beat's expected cycle and contents are derived from the return schedule by the latency rule in R4.

// File: rtl/cwf_reorder.sv
module cwf_reorder #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 32,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int BYTES_W    = $clog2(WORD_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               dn_valid,
  output logic [ADDR_W-1:0]  dn_addr,
  input  logic               ret_valid,
  input  logic [DATA_W-1:0]  ret_data,
  input  logic [BYTES_W-1:0] ret_bytes,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_last,
  output logic               out_err
);
  localparam int BEATS  = LINE_BYTES / WORD_BYTES;
  localparam int IDX_W  = $clog2(BEATS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam int CNT_W  = IDX_W + 1;

  logic              busy;
  logic [IDX_W-1:0]  crit;
  logic [IDX_W-1:0]  kcnt;
  logic [CNT_W-1:0]  wcnt;
  logic [DATA_W-1:0] line_q [BEATS];
  logic [IDX_W-1:0]  want;
  logic              ret_ok;
  logic              beat_rdy;
  logic              unused_low;

  assign unused_low = ^req_addr[WOFF_W-1:0];
  assign dn_valid   = req_valid && !busy;
  assign dn_addr    = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign want       = crit + kcnt;
  assign ret_ok     = ret_valid && (ret_bytes == BYTES_W'(WORD_BYTES));
  assign beat_rdy   = busy && ({1'b0, want} < wcnt);

  always_ff @(posedge clk) begin
    if (busy && !(ret_valid && !ret_ok) && ret_ok && wcnt < CNT_W'(BEATS))
      line_q[wcnt[IDX_W-1:0]] <= ret_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      crit      <= '0;
      kcnt      <= '0;
      wcnt      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy <= 1'b1;
          crit <= req_addr[OFF_W-1:WOFF_W];
          kcnt <= '0;
          wcnt <= '0;
        end
      end else if (ret_valid && !ret_ok) begin
        out_err <= 1'b1;
        busy    <= 1'b0;
        wcnt    <= '0;
      end else begin
        if (ret_ok && wcnt < CNT_W'(BEATS))
          wcnt <= wcnt + 1'b1;
        if (beat_rdy) begin
          out_valid <= 1'b1;
          out_data  <= line_q[want];
          kcnt      <= kcnt + 1'b1;
          if (kcnt == IDX_W'(BEATS - 1)) begin
            out_last <= 1'b1;
            busy     <= 1'b0;
          end
        end
      end
    end
  end

  a_r5_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid && !busy);
  a_r6_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_valid && !busy);
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |=> busy);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !out_valid);
  a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(wcnt) != '0);

endmodule

// File: tb/cwf_reorder_tb_top.sv
module cwf_reorder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        dn_valid;
  logic [31:0] dn_addr;
  logic        ret_valid = 1'b0;
  logic [63:0] ret_data = '0;
  logic [3:0]  ret_bytes = 4'd0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_last;
  logic        out_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cwf_reorder dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .dn_valid(dn_valid), .dn_addr(dn_addr),
    .ret_valid(ret_valid), .ret_data(ret_data), .ret_bytes(ret_bytes),
    .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_err(out_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] wval(input int tag, input int w);
    return {32'(tag) ^ 32'h5A00_0000, 32'hC0DE_0000 | 32'(w)};
  endfunction

  function automatic int gap(input int p, input int w);
    case (p)
      1: return (w == 1) ? 3 : 0;
      2: return (w == 2) ? 2 : 0;
      3: return (w == 0) ? 2 : 1;
      4: return (w == 3) ? 5 : 0;
      5: return (w[0] == 1'b0) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic run_fill(input int tag, input int c, input int lo3, input int p,
                          input bit busyreq, input int errw);
    int a[4];
    int e[4];
    int lim;
    int aerr;
    logic [31:0] addr;
    addr = 32'h1234_0000 + (32'(tag) << 8) + (32'(c) << 3) + 32'(lo3);
    for (int w = 0; w < 4; w++) begin
      a[w] = ((w == 0) ? 1 : a[w-1] + 1) + gap(p, w);
      if (errw >= 0 && w > errw) a[w] = 100000;
    end
    aerr = (errw >= 0) ? a[errw] : 100000;
    for (int k = 0; k < 4; k++) begin
      e[k] = a[(c + k) % 4] + 2;
      if (k > 0 && e[k-1] + 1 > e[k]) e[k] = e[k-1] + 1;
    end
    lim = (errw < 0) ? e[3] + 2 : aerr + 4;
    for (int i = 0; i <= lim; i++) begin
      int kk;
      @(negedge clk);
      kk = -1;
      for (int k = 0; k < 4; k++)
        if (e[k] == i && (errw < 0 || e[k] <= aerr)) kk = k;
      // R4: beat timing
      chk("R4 beat valid", 64'(out_valid), 64'(kk >= 0));
      if (kk >= 0 && out_valid) begin
        chk("R3 beat data", out_data, wval(tag, (c + kk) % 4));
        chk("R5 last flag", 64'(out_last), 64'(kk == 3));
      end
      chk("R6 error flag", 64'(out_err), 64'(errw >= 0 && i == aerr + 1));
      req_valid = (i == 0) || (busyreq && i == 1);
      req_addr  = (i == 0) ? addr : (addr ^ 32'h0000_0F18);
      ret_valid = 1'b0;
      ret_bytes = 4'd0;
      for (int w = 0; w < 4; w++)
        if (a[w] == i) begin
          ret_valid = 1'b1;
          ret_data  = wval(tag, w);
          ret_bytes = (w == errw) ? 4'd4 : 4'd8;
        end
      #1;
      if (i == 0) begin
        chk("R1 forward valid", 64'(dn_valid), 64'd1);
        chk("R1 aligned addr", 64'(dn_addr), 64'(addr & 32'hFFFF_FFE0));
      end
      if (i == 1 && busyreq)
        chk("R2 busy request blocked", 64'(dn_valid), 64'd0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    ret_valid = 1'b0;
    ret_bytes = 4'd0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int tag;
    tag = 1;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 valid in reset", 64'(out_valid), 64'd0);
    chk("R8 last in reset", 64'(out_last), 64'd0);
    chk("R8 err in reset", 64'(out_err), 64'd0);
    chk("R8 no forward in reset", 64'(dn_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    req_addr = 32'h0000_0018;
    req_valid = 1'b1;
    #1;
    chk("R8 idle after reset", 64'(dn_valid), 64'd1);
    req_valid = 1'b0;
    #1;
    // R7: returns while idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 idle out_valid", 64'(out_valid), 64'd0);
      chk("R7 idle out_err", 64'(out_err), 64'd0);
      ret_valid = (i < 3);
      ret_data  = 64'hDEAD_0000_0000_0000 | 64'(i);
      ret_bytes = (i == 1) ? 4'd2 : 4'd8;
    end
    ret_valid = 1'b0;
    // R3 R4 R5 R1 R2: sweep of critical word, offset and split pattern
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 6; p++) begin
        run_fill(tag, c, (c * 3 + p) & 7, p, bit'(p & 1), -1);
        tag++;
      end
    // R6: short piece at each return position
    for (int ew = 0; ew < 4; ew++)
      for (int c = 0; c < 4; c += 2) begin
        run_fill(tag, c, ew, ew + c, 1'b0, ew);
        tag++;
        run_fill(tag, (c + 1) % 4, 0, 0, 1'b0, -1);
        tag++;
      end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule